// File: doc/BRIEF.md
# Privileged Cycle Timer with Match Interrupt

This block holds a free-running cycle count next to a compare register. The most significant bit of the count register is a read-protection flag kept apart from the count itself. When it is set, unprivileged software cannot read the count. The compare register holds a match value below an interrupt-disable flag in its top bit. The block raises a level interrupt when the running count reaches the match value and the flag allows it.

Software reaches both registers through a one-cycle write port and a read port. A select bit on each port picks the register. The read port also takes a privilege bit. A read returns its data one cycle after the request, marked by a valid strobe. A blocked read returns zero and raises a fault strobe in the same cycle. Trap handling and interrupt routing belong to the logic that consumes these outputs.

Top module: `tick_timer`

## Requirements
- R1: After reset the 63-bit count is zero and the read-protection flag (bit 63 of the count register) is 1.
- R2: After reset the compare register reads with its disable flag (bit 63) at 1 and its 63-bit match field at zero, and `timer_irq` is 0.
- R3: A write with `wr_sel`=0 loads the count from `wr_data[62:0]` and the protection flag from `wr_data[63]` at the next clock edge. On every edge without such a write, the count increases by one.
- R4: A read with `rd_sel`=0 that is privileged, or made while the protection flag is 0, returns {flag, count} as sampled at the request edge, with `rd_valid` high one cycle after `rd_en`.
- R5: An unprivileged read with `rd_sel`=0 while the protection flag is 1 returns zero data and raises `priv_fault` for exactly that one result cycle.
- R6: The count wraps from all ones to zero within its 63 bits.
- R7: A write with `wr_sel`=1 loads {disable, match} from `wr_data` at the next edge. A read with `rd_sel`=1 returns {disable, match} at any privilege, with no fault.
- R8: With disable at 0, `timer_irq` goes high on the edge after the cycle in which the count equals the match field, and stays high.
- R9: Any write to the compare register drives `timer_irq` low at that write's edge.
- R10: While the disable flag is 1, `timer_irq` is low from the next edge on and never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 compare |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read target: 0 count, 1 compare |
| rd_priv | input | 1 | Read is made at privileged level |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Read result |
| priv_fault | output | 1 | Read was blocked by the protection flag |
| timer_irq | output | 1 | Match interrupt, level |

## Verification
A read result is due one cycle after its request. The scoreboard queues the expected value when the request is driven, and the monitor pops it on the next falling edge that shows `rd_valid`. Expected counts come from the cycle index of the last count write: the value written, plus the cycles elapsed since its edge, minus one. This follows from the register sampling at the request edge. The interrupt is due one edge after the count equals the match value. The bench therefore samples it on the falling edge just before that edge and on the one just after. A cleared interrupt is checked on the falling edge after the edge of the clearing write.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic {
      TREG_COUNT = 1'b0,
      TREG_CMP   = 1'b1
   } treg_e;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
   parameter int CNT_W = 64,
   localparam int VW = CNT_W - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [CNT_W-1:0] load_data,
   output logic [VW-1:0] count_o,
   output logic          guard_o
);
   logic [VW-1:0] count_q;
   logic          guard_q;
   logic          past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         guard_q <= 1'b1;
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (load_en) begin
            count_q <= load_data[VW-1:0];
            guard_q <= load_data[CNT_W-1];
         end else begin
            count_q <= count_q + 1'b1;
         end
      end
   end

   assign count_o = count_q;
   assign guard_o = guard_q;

   // R3 / R6: free-running increment with modular wrap
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(load_en)) |-> (count_q == VW'($past(count_q) + 1'b1)));
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (guard_q == $past(load_data[CNT_W-1])));
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
   parameter int CNT_W = 64,
   localparam int VW = CNT_W - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [CNT_W-1:0] load_data,
   input  logic [VW-1:0] count_i,
   output logic [VW-1:0] match_o,
   output logic          mask_o,
   output logic          irq_o
);
   logic [VW-1:0] match_q;
   logic          mask_q;
   logic          irq_q;
   logic          hit;

   assign hit = (count_i == match_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= '0;
         mask_q  <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         if (load_en) begin
            match_q <= load_data[VW-1:0];
            mask_q  <= load_data[CNT_W-1];
         end
         if (load_en || mask_q)
            irq_q <= 1'b0;
         else if (hit)
            irq_q <= 1'b1;
      end
   end

   assign match_o = match_q;
   assign mask_o  = mask_q;
   assign irq_o   = irq_q;

   a_r8_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(count_i == match_q && !mask_q));
   a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> !irq_q);
   a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |=> !irq_q);
endmodule

// File: rtl/tick_readout.sv
module tick_readout
   import tick_pkg::*;
#(
   parameter int CNT_W = 64,
   localparam int VW = CNT_W - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  treg_e         rd_sel,
   input  logic          rd_priv,
   input  logic [VW-1:0] count_i,
   input  logic          guard_i,
   input  logic [VW-1:0] match_i,
   input  logic          mask_i,
   output logic          valid_o,
   output logic [CNT_W-1:0] data_o,
   output logic          fault_o
);
   logic             valid_q, fault_q;
   logic [CNT_W-1:0] data_q;
   logic             blocked;

   assign blocked = (rd_sel == TREG_COUNT) && guard_i && !rd_priv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         fault_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= rd_en;
         fault_q <= rd_en && blocked;
         if (!rd_en || blocked)
            data_q <= '0;
         else if (rd_sel == TREG_COUNT)
            data_q <= {guard_i, count_i};
         else
            data_q <= {mask_i, match_i};
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;
   assign fault_o = fault_q;

   a_r4_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> valid_q);
   a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> (valid_q && data_q == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int CNT_W = 64,
   localparam int VW = CNT_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             rd_en,
   input  logic             rd_sel,
   input  logic             rd_priv,
   output logic             rd_valid,
   output logic [CNT_W-1:0] rd_data,
   output logic             priv_fault,
   output logic             timer_irq
);
   generate
      if (CNT_W < 8 || CNT_W > 64) begin : g_bad_width
         $error("tick_timer: CNT_W must lie in 8..64");
      end
   endgenerate

   treg_e         wsel, rsel;
   logic          cnt_load, cmp_load;
   logic [VW-1:0] count, match;
   logic          guard, mask;

   assign wsel     = treg_e'(wr_sel);
   assign rsel     = treg_e'(rd_sel);
   assign cnt_load = wr_en && (wsel == TREG_COUNT);
   assign cmp_load = wr_en && (wsel == TREG_CMP);

   tick_counter #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load_en(cnt_load), .load_data(wr_data),
      .count_o(count), .guard_o(guard));

   tick_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .load_en(cmp_load), .load_data(wr_data),
      .count_i(count), .match_o(match), .mask_o(mask), .irq_o(timer_irq));

   tick_readout #(.CNT_W(CNT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rsel), .rd_priv(rd_priv),
      .count_i(count), .guard_i(guard), .match_i(match), .mask_i(mask),
      .valid_o(rd_valid), .data_o(rd_data), .fault_o(priv_fault));
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
   localparam int W = 64;
   localparam int VW = W - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0, wr_sel = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         rd_en = 1'b0, rd_sel = 1'b0, rd_priv = 1'b0;
   logic         rd_valid, priv_fault, timer_irq;
   logic [W-1:0] rd_data;

   int total = 0;
   int bad = 0;
   longint cyc = 0;
   bit finished = 0;

   typedef struct {
      logic [W-1:0] data;
      logic         fault;
      string        tag;
   } exp_t;
   exp_t sb[$];

   // count model state: value written and cycle index of the write drive
   logic [VW-1:0] base_val;
   longint        base_cyc;
   logic          guard_m;

   tick_timer #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_priv(rd_priv), .rd_valid(rd_valid),
      .rd_data(rd_data), .priv_fault(priv_fault), .timer_irq(timer_irq));

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pop expected items as results appear
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb.size() == 0) chk(0, "R4 unexpected result", rd_data, '0);
         else begin
            exp_t e;
            e = sb.pop_front();
            chk(rd_data == e.data, e.tag, rd_data, e.data);
            chk(priv_fault == e.fault, {e.tag, " fault"}, W'(priv_fault), W'(e.fault));
         end
      end
   end

   function automatic logic [W-1:0] cnt_exp(input longint m);
      logic [VW-1:0] v;
      v = base_val + VW'(m - base_cyc - 1);
      return {guard_m, v};
   endfunction

   task automatic wr(input logic sel, input logic [W-1:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
      if (!sel) begin base_val = d[VW-1:0]; base_cyc = cyc; guard_m = d[W-1]; end
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic sel, input logic priv, input logic [W-1:0] d,
                     input logic f, input string tag);
      exp_t e;
      e.data = d; e.fault = f; e.tag = tag;
      sb.push_back(e);
      rd_en = 1; rd_sel = sel; rd_priv = priv;
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic wait_to(input longint c);
      while (cyc < c) @(negedge clk);
   endtask

   initial begin
      longint n;
      repeat (3) @(negedge clk);
      chk(rd_valid == 0 && timer_irq == 0, "R2 reset outputs", W'(timer_irq), '0);
      // release: equivalent to count 0 written one cycle earlier
      rst_n = 1; base_val = '0; base_cyc = cyc - 1; guard_m = 1;
      rd(0, 1, {1'b1, 63'd0}, 0, "R1 reset count");
      rd(1, 1, {1'b1, 63'd0}, 0, "R2 reset compare");
      // R5 blocked unprivileged read, then fault gone
      rd(0, 0, '0, 1, "R5 blocked read");
      @(negedge clk);
      chk(priv_fault == 0, "R5 fault single pulse", W'(priv_fault), '0);
      // R3 / R4 count load with flag clear, unprivileged allowed
      wr(0, 64'd100);
      @(negedge clk);
      rd(0, 0, cnt_exp(cyc), 0, "R4 unpriv read flag clear");
      // R3 load with flag set, privileged read
      wr(0, {1'b1, 63'd5000});
      @(negedge clk); @(negedge clk);
      rd(0, 1, cnt_exp(cyc), 0, "R3 load with flag");
      // R7 compare read needs no privilege
      rd(1, 0, {1'b1, 63'd0}, 0, "R7 compare unpriv read");
      // R6 wrap
      wr(0, {1'b0, {62{1'b1}}, 1'b0});
      n = base_cyc;
      wait_to(n + 4);
      rd(0, 0, {1'b0, 63'd1}, 0, "R6 wrap");
      // R8 match interrupt
      wr(0, 64'd1000);
      n = base_cyc;
      wr(1, {1'b0, 63'd1010});
      rd(1, 0, {1'b0, 63'd1010}, 0, "R7 compare readback");
      wait_to(n + 11);
      chk(timer_irq == 0, "R8 irq before match", W'(timer_irq), '0);
      @(negedge clk);
      chk(timer_irq == 1, "R8 irq at match", W'(timer_irq), 1);
      repeat (4) @(negedge clk);
      chk(timer_irq == 1, "R8 irq level held", W'(timer_irq), 1);
      // R9 compare write clears
      wr(1, {1'b0, 63'h7000_0000});
      chk(timer_irq == 0, "R9 write clears irq", W'(timer_irq), '0);
      // R10 disabled match never fires
      wr(0, 64'd2000);
      n = base_cyc;
      wr(1, {1'b1, 63'd2005});
      wait_to(n + 10);
      chk(timer_irq == 0, "R10 disabled no irq", W'(timer_irq), '0);
      // R10 cancel a pending level by setting disable
      wr(0, 64'd3000);
      n = base_cyc;
      wr(1, {1'b0, 63'd3004});
      wait_to(n + 6);
      chk(timer_irq == 1, "R8 irq before cancel", W'(timer_irq), 1);
      wr(1, {1'b1, 63'd3004});
      chk(timer_irq == 0, "R10 disable cancels", W'(timer_irq), '0);
      repeat (3) @(negedge clk);
      chk(timer_irq == 0, "R10 stays low", W'(timer_irq), '0);
      repeat (2) @(negedge clk);
      chk(sb.size() == 0, "R4 all results seen", W'(sb.size()), '0);
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule